// File: doc/BRIEF.md
# Shared Single-Port Memory Front End

This block lets several processor ports share one single-ported storage array of 8192 sixteen-bit words (16 KB). In any cycle each port may raise a request to read or write. An arbiter picks at most one request, and the chosen access goes to the array. The arbitration order is either a fixed order or a rotating (round-robin) order, set by one input. Ports that are switched off through an enable mask never win.

Each port has its own address generator. A request can carry a plain address. It can also use the generator: either a base plus an offset that steps by a programmable stride, or an offset that stays inside a programmable window and wraps round it. This lets a processor stream through a buffer without computing each address itself.

Generator registers are loaded through a small configuration write path. Read data comes back one cycle after the grant, together with a valid pulse and the index of the port that asked for it.

Top module: `shmem_ctrl`

## Requirements
- R1: While `rst_n` is low no port is granted. After reset `rd_valid` is 0, every generator has base 0, offset 0, stride 1 and window 0, and the round-robin search starts at port 0.
- R2: `p_gnt` has at most one bit set, and only for a port whose `p_req` bit is 1.
- R3: With `rr_mode`=0 the grant goes to the lowest-indexed port that is both requesting and enabled.
- R4: With `rr_mode`=1 the grant goes to the first port that is requesting and enabled, searching upward (and wrapping round) from the port after the one granted last. A cycle with no grant leaves the search start unchanged.
- R5: A port whose `port_en` bit is 0 is never granted, even when it requests.
- R6: Mode code 0 (and code 3) is direct: the access uses that port's `p_addr` field.
- R7: Mode code 1 is stepping: the access address is base + offset, taken modulo 8192. After each grant in this mode the offset grows by the stride, modulo 8192.
- R8: Mode code 2 is ring: the address is formed as in R7. After each grant the new offset is offset + stride, minus the window whenever that sum is greater than or equal to the window.
- R9: A port that requests but is not granted keeps its generator offset, so its next granted access uses the same address.
- R10: A granted read gives `rd_valid`=1 on the next cycle, with `rd_port` equal to the granted index and `rd_data` equal to the word stored at that address. A granted write stores its data and gives `rd_valid`=0 on the next cycle.
- R11: A configuration write with `cfg_field` 0 loads the base of port `cfg_port` and clears its offset. Field 1 loads the stride, field 2 loads the window, and field 3 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| port_en | input | NPORT | Per-port enable mask |
| rr_mode | input | 1 | 0 = fixed order, 1 = rotating order |
| cfg_wr | input | 1 | Generator register write strobe |
| cfg_port | input | PW | Port whose generator is written |
| cfg_field | input | 2 | 0 base, 1 stride, 2 window, 3 none |
| cfg_data | input | AW | Value written |
| p_req | input | NPORT | Request per port |
| p_we | input | NPORT | 1 = write, 0 = read, per port |
| p_mode | input | 2*NPORT | Address mode per port, two bits each |
| p_addr | input | AW*NPORT | Direct address per port |
| p_wdata | input | DW*NPORT | Write data per port |
| p_gnt | output | NPORT | One-hot grant, same cycle as the request |
| rd_valid | output | 1 | Read data valid pulse |
| rd_port | output | PW | Port the read data belongs to |
| rd_data | output | DW | Read data |

## Verification
The bench goes after the rotating pointer in three situations: just after fixed-order grants, when the next requester in line is disabled, and when a cycle has no grant. An arbiter that moved its pointer on an empty cycle, or that skipped the enable mask, would hand the grant to the wrong port. The bench also steps a generator across the top of the array, and drives a ring whose stride does not divide the window. A generator that saturated, or that wrapped to zero instead of to the remainder, would read the wrong words. It also makes a port lose arbitration while in stepping mode, and reloads a base partway through a ring. A design that advanced a loser's offset, or kept the offset when the base was reloaded, would return data from a skipped address.

// File: rtl/shmem_pkg.sv
`timescale 1ns/1ps
// Package: shared encodings of the shared-memory front end.
// Assumes: every block that decodes a mode or a config field imports it.
package shmem_pkg;

    // Per-request address mode, two bits on each port.
    typedef enum logic [1:0] {
        AM_DIRECT = 2'd0,
        AM_STEP   = 2'd1,
        AM_RING   = 2'd2,
        AM_ALT    = 2'd3
    } amode_e;

    // Generator register selector on the configuration path.
    typedef enum logic [1:0] {
        CF_BASE   = 2'd0,
        CF_STRIDE = 2'd1,
        CF_WINDOW = 2'd2,
        CF_NONE   = 2'd3
    } cfield_e;

endpackage

// File: rtl/shmem_arb.sv
`timescale 1ns/1ps
// Module: shmem_arb
// Picks one of NPORT qualified requests, either lowest index first or in
// rotating order starting after the last winner.
// Assumes: req is already masked by enables and reset; NPORT >= 2.
module shmem_arb #(
    parameter int NPORT = 4,
    parameter int PW    = $clog2(NPORT)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rr,
    input  logic [NPORT-1:0] req,
    output logic [NPORT-1:0] gnt,
    output logic [PW-1:0]    gnt_idx,
    output logic             any
);

    logic [PW-1:0] ptr_q;
    logic [PW-1:0] pick;
    logic [PW-1:0] cand;
    logic          found;

    // Purpose: choose the winning index for this cycle.
    always_comb begin
        found = 1'b0;
        pick  = '0;
        cand  = '0;
        if (!rr) begin
            for (int i = NPORT - 1; i >= 0; i--) begin
                if (req[i]) begin
                    pick  = PW'(i);
                    found = 1'b1;
                end
            end
        end else begin
            for (int k = 1; k <= NPORT; k++) begin
                cand = PW'((int'(ptr_q) + k) % NPORT);
                if (!found && req[cand]) begin
                    pick  = cand;
                    found = 1'b1;
                end
            end
        end
    end

    // Purpose: expand the winner into a one-hot grant.
    always_comb begin
        gnt = '0;
        if (found) gnt[pick] = 1'b1;
        gnt_idx = pick;
        any     = found;
    end

    // Purpose: remember the last winner for rotating order.
    always_ff @(posedge clk) begin
        if (!rst_n)     ptr_q <= PW'(NPORT - 1);
        else if (found) ptr_q <= pick;
    end

endmodule

// File: rtl/shmem_agen.sv
`timescale 1ns/1ps
// Module: shmem_agen
// Address generator of one port. It covers the direct, stepping and ring
// modes, and holds base, stride, window and the running offset.
// Assumes: adv is high only in a cycle where this port is granted; a
// configuration write in the same cycle takes precedence over advancing.
module shmem_agen
    import shmem_pkg::*;
#(
    parameter int AW = 13
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_wr,
    input  logic [1:0]    cfg_field,
    input  logic [AW-1:0] cfg_data,
    input  logic [1:0]    mode,
    input  logic [AW-1:0] dir_addr,
    input  logic          adv,
    output logic [AW-1:0] addr
);

    logic [AW-1:0] base_q;
    logic [AW-1:0] stride_q;
    logic [AW-1:0] win_q;
    logic [AW-1:0] off_q;
    logic [AW-1:0] off_nxt;
    logic [AW:0]   sum_w;
    logic          gen_mode;

    // Purpose: flag the modes that use the generator.
    always_comb gen_mode = (mode == AM_STEP) || (mode == AM_RING);

    // Purpose: form the next offset, wrapping inside the window in ring mode.
    always_comb begin
        sum_w   = {1'b0, off_q} + {1'b0, stride_q};
        off_nxt = sum_w[AW-1:0];
        if (mode == AM_RING && sum_w >= {1'b0, win_q})
            off_nxt = AW'(sum_w - {1'b0, win_q});
    end

    // Purpose: select the address presented for this port.
    always_comb addr = gen_mode ? AW'(base_q + off_q) : dir_addr;

    // Purpose: hold the generator registers and advance on grant.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q   <= '0;
            stride_q <= AW'(1);
            win_q    <= '0;
            off_q    <= '0;
        end else if (cfg_wr) begin
            case (cfg_field)
                CF_BASE: begin
                    base_q <= cfg_data;
                    off_q  <= '0;
                end
                CF_STRIDE: stride_q <= cfg_data;
                CF_WINDOW: win_q    <= cfg_data;
                default: ;
            endcase
        end else if (adv && gen_mode) begin
            off_q <= off_nxt;
        end
    end

endmodule

// File: rtl/shmem_ram.sv
`timescale 1ns/1ps
// Module: shmem_ram
// Inferred synchronous single-port RAM: one read or one write per cycle.
// Read data is registered and appears the cycle after the access.
// Assumes: contents are not reset; rdata holds when no read is made.
module shmem_ram #(
    parameter int AW = 13,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          en,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);

    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    // Purpose: perform the single access of this cycle.
    always_ff @(posedge clk) begin
        if (en) begin
            if (we) mem[addr] <= wdata;
            else    rdata     <= mem[addr];
        end
    end

endmodule

// File: rtl/shmem_ctrl.sv
`timescale 1ns/1ps
// Module: shmem_ctrl (top)
// Front end that shares one single-port array among NPORT requesters. It
// arbitrates the requests, generates an address for each port, and returns
// read data tagged with the port index.
// Assumes: all ports share clk; requesters hold a request until granted.
module shmem_ctrl
    import shmem_pkg::*;
#(
    parameter int NPORT = 4,
    parameter int AW    = 13,
    parameter int DW    = 16,
    localparam int PW   = $clog2(NPORT)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NPORT-1:0]    port_en,
    input  logic                rr_mode,
    input  logic                cfg_wr,
    input  logic [PW-1:0]       cfg_port,
    input  logic [1:0]          cfg_field,
    input  logic [AW-1:0]       cfg_data,
    input  logic [NPORT-1:0]    p_req,
    input  logic [NPORT-1:0]    p_we,
    input  logic [2*NPORT-1:0]  p_mode,
    input  logic [AW*NPORT-1:0] p_addr,
    input  logic [DW*NPORT-1:0] p_wdata,
    output logic [NPORT-1:0]    p_gnt,
    output logic                rd_valid,
    output logic [PW-1:0]       rd_port,
    output logic [DW-1:0]       rd_data
);

    logic [NPORT-1:0] req_q;
    logic [PW-1:0]    win_idx;
    logic             win_any;
    logic [AW-1:0]    gen_addr [NPORT];
    logic [AW-1:0]    sel_addr;
    logic [DW-1:0]    sel_wdata;
    logic             sel_we;

    // Purpose: qualify requests with enables and hold them off in reset.
    always_comb req_q = p_req & port_en & {NPORT{rst_n}};

    shmem_arb #(.NPORT(NPORT), .PW(PW)) u_arb (
        .clk     (clk),
        .rst_n   (rst_n),
        .rr      (rr_mode),
        .req     (req_q),
        .gnt     (p_gnt),
        .gnt_idx (win_idx),
        .any     (win_any)
    );

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        logic cfg_hit;

        // Purpose: decode configuration writes aimed at this port.
        always_comb cfg_hit = cfg_wr && (cfg_port == PW'(p));

        shmem_agen #(.AW(AW)) u_agen (
            .clk       (clk),
            .rst_n     (rst_n),
            .cfg_wr    (cfg_hit),
            .cfg_field (cfg_field),
            .cfg_data  (cfg_data),
            .mode      (p_mode[2*p +: 2]),
            .dir_addr  (p_addr[AW*p +: AW]),
            .adv       (p_gnt[p]),
            .addr      (gen_addr[p])
        );
    end

    // Purpose: route the winner's address, data and direction to the array.
    always_comb begin
        sel_addr  = gen_addr[win_idx];
        sel_wdata = p_wdata[DW*win_idx +: DW];
        sel_we    = p_we[win_idx];
    end

    shmem_ram #(.AW(AW), .DW(DW)) u_ram (
        .clk   (clk),
        .en    (win_any),
        .we    (sel_we),
        .addr  (sel_addr),
        .wdata (sel_wdata),
        .rdata (rd_data)
    );

    // Purpose: tag the returning read with a valid pulse and port index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_port  <= '0;
        end else begin
            rd_valid <= win_any && !sel_we;
            rd_port  <= win_idx;
        end
    end

endmodule

// File: rtl/shmem_ctrl_chk.sv
`timescale 1ns/1ps
// Module: shmem_ctrl_chk
// Property checker for shmem_ctrl, attached through bind.
// Assumes: it sees only top-level ports.
module shmem_ctrl_chk #(
    parameter int NPORT = 4,
    parameter int PW    = $clog2(NPORT)
) (
    input logic             clk,
    input logic             rst_n,
    input logic [NPORT-1:0] port_en,
    input logic             rr_mode,
    input logic [NPORT-1:0] p_req,
    input logic [NPORT-1:0] p_we,
    input logic [NPORT-1:0] p_gnt,
    input logic             rd_valid,
    input logic [PW-1:0]    rd_port
);

    logic [NPORT-1:0] gnt_d;
    logic             rd_gnt;

    // Purpose: remember the previous grant to check the read tag.
    always_ff @(posedge clk) gnt_d <= p_gnt;

    // Purpose: flag a granted read in this cycle.
    always_comb rd_gnt = |(p_gnt & ~p_we);

    AST_RESET_IDLE: assert property (@(posedge clk)
        !rst_n |-> (p_gnt == '0));                                   // R1
    AST_GNT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(p_gnt));                                            // R2
    AST_GNT_HAS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (p_gnt & ~p_req) == '0);                                     // R2
    AST_FIXED_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
        (!rr_mode && p_gnt != '0) |-> (((p_gnt - 1'b1) & p_req & port_en) == '0)); // R3
    AST_NO_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        (p_gnt & ~port_en) == '0);                                   // R5
    AST_READ_RETURNS: assert property (@(posedge clk) disable iff (!rst_n)
        rd_gnt |=> rd_valid);                                        // R10
    AST_NO_STRAY_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_gnt |=> !rd_valid);                                      // R10
    AST_TAG_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> gnt_d[rd_port]);                                // R10

endmodule

bind shmem_ctrl shmem_ctrl_chk #(.NPORT(NPORT)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .port_en  (port_en),
    .rr_mode  (rr_mode),
    .p_req    (p_req),
    .p_we     (p_we),
    .p_gnt    (p_gnt),
    .rd_valid (rd_valid),
    .rd_port  (rd_port)
);

// File: tb/sim_shmem_ctrl.sv
`timescale 1ns/1ps
module sim_shmem_ctrl;

    localparam int NPORT = 4;
    localparam int AW    = 13;
    localparam int DW    = 16;
    localparam int PW    = 2;

    typedef struct packed {
        logic [3:0] en;
        logic       rr;
        logic [3:0] req;
        logic [3:0] gnt;
    } arb_vec_t;

    localparam int NVEC = 13;
    localparam arb_vec_t ARB_TAB [NVEC] = '{
        '{4'hF, 1'b0, 4'hF, 4'h1},
        '{4'hF, 1'b0, 4'hE, 4'h2},
        '{4'hF, 1'b0, 4'hC, 4'h4},
        '{4'hB, 1'b0, 4'hC, 4'h8},
        '{4'h0, 1'b0, 4'hF, 4'h0},
        '{4'hF, 1'b1, 4'hF, 4'h1},
        '{4'hF, 1'b1, 4'hF, 4'h2},
        '{4'hF, 1'b1, 4'hF, 4'h4},
        '{4'hF, 1'b1, 4'h9, 4'h8},
        '{4'hF, 1'b1, 4'h9, 4'h1},
        '{4'hD, 1'b1, 4'h6, 4'h4},
        '{4'hD, 1'b1, 4'h2, 4'h0},
        '{4'hF, 1'b1, 4'hF, 4'h8}
    };

    logic                clk = 1'b0;
    logic                rst_n;
    logic [NPORT-1:0]    port_en;
    logic                rr_mode;
    logic                cfg_wr;
    logic [PW-1:0]       cfg_port;
    logic [1:0]          cfg_field;
    logic [AW-1:0]       cfg_data;
    logic [NPORT-1:0]    p_req;
    logic [NPORT-1:0]    p_we;
    logic [2*NPORT-1:0]  p_mode;
    logic [AW*NPORT-1:0] p_addr;
    logic [DW*NPORT-1:0] p_wdata;
    logic [NPORT-1:0]    p_gnt;
    logic                rd_valid;
    logic [PW-1:0]       rd_port;
    logic [DW-1:0]       rd_data;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    shmem_ctrl #(.NPORT(NPORT), .AW(AW), .DW(DW)) u0 (.*);

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic acc(input int p, input logic we, input logic [1:0] md,
                       input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        p_req               = '0;
        p_req[p]            = 1'b1;
        p_we                = '0;
        p_we[p]             = we;
        p_mode[2*p +: 2]    = md;
        p_addr[AW*p +: AW]  = a;
        p_wdata[DW*p +: DW] = d;
        @(negedge clk);
        p_req = '0;
        p_we  = '0;
    endtask

    task automatic cfg(input int p, input logic [1:0] f, input logic [AW-1:0] v);
        @(negedge clk);
        cfg_wr    = 1'b1;
        cfg_port  = PW'(p);
        cfg_field = f;
        cfg_data  = v;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic chk_rd(input string tag, input int p, input logic [DW-1:0] exp);
        chk(tag, "rd_valid", 32'(rd_valid), 32'd1);
        chk(tag, "rd_port",  32'(rd_port),  32'(p));
        chk(tag, "rd_data",  32'(rd_data),  32'(exp));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        rst_n = 1'b0; port_en = 4'hF; rr_mode = 1'b0; cfg_wr = 1'b0;
        cfg_port = '0; cfg_field = '0; cfg_data = '0;
        p_req = '0; p_we = '0; p_mode = '0; p_addr = '0; p_wdata = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        p_req = 4'hF;
        #2;
        chk("R1", "p_gnt in reset", 32'(p_gnt), 32'd0);
        chk("R1", "rd_valid in reset", 32'(rd_valid), 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        p_req = '0;

        // arbitration table: every port reads in direct mode
        for (int i = 0; i < NVEC; i++) begin
            @(negedge clk);
            port_en = ARB_TAB[i].en;
            rr_mode = ARB_TAB[i].rr;
            p_req   = ARB_TAB[i].req;
            #2;
            if (ARB_TAB[i].en != 4'hF)
                chk("R5", "p_gnt", 32'(p_gnt), 32'(ARB_TAB[i].gnt));
            else if (ARB_TAB[i].rr)
                chk("R4", "p_gnt", 32'(p_gnt), 32'(ARB_TAB[i].gnt));
            else
                chk("R3", "p_gnt", 32'(p_gnt), 32'(ARB_TAB[i].gnt));
        end
        @(negedge clk);
        p_req = '0; port_en = 4'hF; rr_mode = 1'b0;

        // fill words 0..15 and the top two words, direct writes on port 0
        for (int k = 0; k < 16; k++) acc(0, 1'b1, 2'd0, AW'(k), 16'hA000 + 16'(k));
        chk("R10", "rd_valid after write", 32'(rd_valid), 32'd0);
        acc(0, 1'b1, 2'd0, 13'd8190, 16'hBFFE);
        acc(0, 1'b1, 2'd0, 13'd8191, 16'hBFFF);

        // direct reads, including mode code 3
        acc(2, 1'b0, 2'd0, 13'd5, 16'h0);
        chk_rd("R6", 2, 16'hA005);
        acc(3, 1'b0, 2'd3, 13'd8191, 16'h0);
        chk_rd("R6", 3, 16'hBFFF);

        // stepping across the top of the array on port 1
        cfg(1, 2'd0, 13'd8190);
        acc(1, 1'b0, 2'd1, 13'd0, 16'h0);
        chk_rd("R7", 1, 16'hBFFE);
        acc(1, 1'b0, 2'd1, 13'd0, 16'h0);
        chk_rd("R7", 1, 16'hBFFF);
        acc(1, 1'b0, 2'd1, 13'd0, 16'h0);
        chk_rd("R7", 1, 16'hA000);

        // ring on port 2: base 4, stride 3, window 8 -> 4,7,10,5,8,11,6
        cfg(2, 2'd0, 13'd4);
        cfg(2, 2'd1, 13'd3);
        cfg(2, 2'd2, 13'd8);
        cfg(2, 2'd3, 13'd1);
        begin
            int exp_a [7] = '{4, 7, 10, 5, 8, 11, 6};
            for (int j = 0; j < 7; j++) begin
                acc(2, 1'b0, 2'd2, 13'd0, 16'h0);
                chk_rd("R8", 2, 16'hA000 + 16'(exp_a[j]));
            end
        end
        // reload base: offset returns to zero
        cfg(2, 2'd0, 13'd4);
        acc(2, 1'b0, 2'd2, 13'd0, 16'h0);
        chk_rd("R11", 2, 16'hA004);

        // port 3 loses to port 0 in fixed order; its offset must not move
        cfg(3, 2'd1, 13'd2);
        @(negedge clk);
        p_req = 4'h9; p_we = '0;
        p_mode[1:0] = 2'd0; p_addr[AW-1:0] = 13'd7;
        p_mode[7:6] = 2'd1;
        #2;
        chk("R3", "p_gnt port 0 over 3", 32'(p_gnt), 32'h1);
        @(negedge clk);
        p_req = 4'h8;
        chk_rd("R10", 0, 16'hA007);
        #2;
        chk("R9", "p_gnt port 3", 32'(p_gnt), 32'h8);
        @(negedge clk);
        p_req = '0;
        chk_rd("R9", 3, 16'hA000);
        acc(3, 1'b0, 2'd1, 13'd0, 16'h0);
        chk_rd("R7", 3, 16'hA002);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule